// File: doc/BRIEF.md
# Order Message Sequencer

This block is the control engine of one instrument's order book. It takes one decoded order message at a time: add, execute, cancel, delete or replace. It applies the message to an order store that the block holds itself. The store has 1024 slots, and the slot is chosen by the low bits of the 64-bit order reference. Each change to the store is then turned into add or remove commands for an external price-level table. After those commands, the block starts an external best-price scanner and waits for the scanner to report completion.

Every message follows the same fixed path through a sequence of states. Messages that need an existing order first read the store, and that read takes two cycles. The order update comes next. A two-cycle settling gap then leads to the level command or commands. A second two-cycle gap follows each level command, then the scan request, then the wait for the scanner. The block keeps running counts of live buy orders and live sell orders. It also keeps a lifetime count of the messages it has accepted, and it raises `busy` while a message is in progress.

Top module: `order_msg_sequencer`

## Requirements
- R1: When `busy` is low and `msg_valid` is high with `msg_kind` equal to 1 (add), 2 (execute), 3 (cancel), 4 (delete) or 5 (replace), the message is accepted and `busy` is high in the next cycle. Any other kind code is ignored: `busy` stays low and no counter changes.
- R2: An add message whose slot (`msg_ref[9:0]`) is free stores the order. One level command with `lvl_cmd_add`=1 carries the message's price, shares and side (0 = buy, 1 = sell), and it appears in the 4th cycle after acceptance. The live count for that side increases by one.
- R3: Execute, cancel, delete and replace read the stored entry first. Their first level command appears in the 7th cycle after acceptance.
- R4: If the slot is not live, or if its stored reference differs from `msg_ref`, the message produces no level command and no scan, and the store and the live counts stay unchanged.
- R5: Execute and cancel issue a remove (`lvl_cmd_add`=0) at the stored price and side. The removed quantity is the smaller of the requested shares and the remaining shares, and the remaining shares drop by that amount.
- R6: When an execute or cancel leaves zero shares, the order stops being live, and the live count for its side decreases by one.
- R7: A delete removes all remaining shares at the stored price and side, the order stops being live, and the live count for its side decreases by one.
- R8: A replace first removes the old order's shares at its old price. Three cycles later it adds the new shares at the new price on the same side. The order then lives under `msg_new_ref`, and the old reference no longer matches. The live counts do not change.
- R9: `scan_start` is a one-cycle pulse that appears 3 cycles after the last level command. The message completes only after `scan_done` has been seen, and `scan_done` is sampled from the cycle after the pulse onward.
- R10: `msg_count` increases by exactly one per accepted message, in the cycle in which `busy` falls.
- R11: An add whose slot is already live, or a replace whose new slot is already live under another slot index, is refused. It produces no level command and no scan, and the counts and the store do not change.
- R12: A level command and a scan pulse never occur in the same cycle. Each lasts one cycle, and neither occurs while `busy` is low.
- R13: Synchronous reset clears `busy`, both live counts, `msg_count` and every live flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| msg_valid | input | 1 | Message present |
| msg_kind | input | 3 | 1 add, 2 execute, 3 cancel, 4 delete, 5 replace |
| msg_ref | input | 64 | Order reference; low 10 bits select the slot |
| msg_price | input | 32 | Price, used by add |
| msg_shares | input | 32 | Shares for add, or shares to take for execute/cancel |
| msg_side | input | 1 | Side for add: 0 buy, 1 sell |
| msg_new_ref | input | 64 | Replacement reference |
| msg_new_price | input | 32 | Replacement price |
| msg_new_shares | input | 32 | Replacement shares |
| lvl_cmd_valid | output | 1 | One-cycle level-table command |
| lvl_cmd_add | output | 1 | 1 add shares, 0 remove shares |
| lvl_cmd_price | output | 32 | Level price |
| lvl_cmd_qty | output | 32 | Shares to add or remove |
| lvl_cmd_side | output | 1 | Level side |
| scan_start | output | 1 | One-cycle scanner trigger |
| scan_done | input | 1 | Scanner finished |
| busy | output | 1 | Message in progress |
| buy_orders | output | 11 | Live buy orders |
| sell_orders | output | 11 | Live sell orders |
| msg_count | output | 32 | Accepted messages since reset |

## Verification
Every result of this block is due at a fixed cycle offset from the acceptance edge. `busy` rises in cycle 1. The first level command arrives in cycle 4 for an add and in cycle 7 for a message that reads the store. A replace's second command follows 3 cycles after its first, and the scan pulse follows 3 cycles after the last command. The bench numbers the cycles after acceptance and samples at each falling edge. It records the cycle in which each command and each scan pulse appears, and compares that number with the offset the requirement gives. It answers each scan 2 cycles after the pulse. The counts are checked once `busy` has fallen.

// File: rtl/oms_pkg.sv
`timescale 1ns/1ps
package oms_pkg;

    localparam int REF_W = 64;
    localparam int PX_W  = 32;
    localparam int QTY_W = 32;
    localparam int MCNT_W = 32;

    typedef enum logic [2:0] {
        K_NONE    = 3'd0,
        K_ADD     = 3'd1,
        K_EXEC    = 3'd2,
        K_CANCEL  = 3'd3,
        K_DELETE  = 3'd4,
        K_REPLACE = 3'd5
    } msg_kind_e;

    // 64 + 32 + 32 + 1 + 1 = 130 bits per slot
    typedef struct packed {
        logic [REF_W-1:0] oref;
        logic [PX_W-1:0]  price;
        logic [QTY_W-1:0] qty;
        logic             side;
        logic             live;
    } order_t;

    typedef enum logic [3:0] {
        S_IDLE, S_LOOKUP, S_LK_WAIT, S_CHECK,
        S_ORD_WR, S_ORD_W1, S_ORD_W2,
        S_LVL, S_LVL_W1, S_LVL_W2,
        S_SCAN, S_SCAN_WAIT, S_DONE
    } seq_state_e;

    function automatic logic kind_known(input logic [2:0] k);
        return (k >= 3'd1) && (k <= 3'd5);
    endfunction

    function automatic logic [QTY_W-1:0] take_qty(input logic [QTY_W-1:0] want,
                                                  input logic [QTY_W-1:0] have);
        return (want > have) ? have : want;
    endfunction

endpackage

// File: rtl/oms_order_store.sv
`timescale 1ns/1ps
module oms_order_store
    import oms_pkg::*;
#(
    parameter int DEPTH = 1024,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  order_t           wr_data,
    input  logic             rd_en,
    input  logic [IDX_W-1:0] rd_idx,
    output order_t           rd_data
);
    order_t           mem [DEPTH];
    logic [IDX_W-1:0] rd_idx_q;
    order_t           rd_data_q;

    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_idx] <= wr_data;
    end

    // two-stage read: address register, then data register
    always_ff @(posedge clk) begin
        if (rd_en) rd_idx_q <= rd_idx;
        rd_data_q <= mem[rd_idx_q];
    end

    assign rd_data = rd_data_q;
endmodule

// File: rtl/oms_live_bits.sv
`timescale 1ns/1ps
module oms_live_bits #(
    parameter int DEPTH = 1024,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             set_en,
    input  logic [IDX_W-1:0] set_idx,
    input  logic             clr_en,
    input  logic [IDX_W-1:0] clr_idx,
    input  logic [IDX_W-1:0] rd_a_idx,
    output logic             rd_a,
    input  logic [IDX_W-1:0] rd_b_idx,
    output logic             rd_b
);
    logic [DEPTH-1:0] live;

    for (genvar i = 0; i < DEPTH; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst)
                live[i] <= 1'b0;
            else if (set_en && set_idx == IDX_W'(i))
                live[i] <= 1'b1;          // set wins over clear
            else if (clr_en && clr_idx == IDX_W'(i))
                live[i] <= 1'b0;
        end
    end

    assign rd_a = live[rd_a_idx];
    assign rd_b = live[rd_b_idx];
endmodule

// File: rtl/oms_side_counts.sv
`timescale 1ns/1ps
module oms_side_counts #(
    parameter int DEPTH = 1024,
    localparam int CW = $clog2(DEPTH) + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          up_en,
    input  logic          up_side,
    input  logic          dn_en,
    input  logic          dn_side,
    output logic [CW-1:0] buy_cnt,
    output logic [CW-1:0] sell_cnt
);
    logic [CW-1:0] cnt [2];

    for (genvar s = 0; s < 2; s++) begin : g_side
        logic inc, dec;
        assign inc = up_en && (up_side == 1'(s));
        assign dec = dn_en && (dn_side == 1'(s));
        always_ff @(posedge clk) begin
            if (rst)
                cnt[s] <= '0;
            else
                cnt[s] <= cnt[s] + {{(CW-1){1'b0}}, inc} - {{(CW-1){1'b0}}, dec};
        end
    end

    assign buy_cnt  = cnt[0];
    assign sell_cnt = cnt[1];
endmodule

// File: rtl/order_msg_sequencer.sv
`timescale 1ns/1ps
module order_msg_sequencer
    import oms_pkg::*;
#(
    parameter int DEPTH = 1024,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              msg_valid,
    input  logic [2:0]        msg_kind,
    input  logic [REF_W-1:0]  msg_ref,
    input  logic [PX_W-1:0]   msg_price,
    input  logic [QTY_W-1:0]  msg_shares,
    input  logic              msg_side,
    input  logic [REF_W-1:0]  msg_new_ref,
    input  logic [PX_W-1:0]   msg_new_price,
    input  logic [QTY_W-1:0]  msg_new_shares,
    output logic              lvl_cmd_valid,
    output logic              lvl_cmd_add,
    output logic [PX_W-1:0]   lvl_cmd_price,
    output logic [QTY_W-1:0]  lvl_cmd_qty,
    output logic              lvl_cmd_side,
    output logic              scan_start,
    input  logic              scan_done,
    output logic              busy,
    output logic [IDX_W:0]    buy_orders,
    output logic [IDX_W:0]    sell_orders,
    output logic [MCNT_W-1:0] msg_count
);
    seq_state_e        state;
    msg_kind_e         m_kind;
    logic [REF_W-1:0]  m_ref, m_nref;
    logic [PX_W-1:0]   m_price, m_nprice;
    logic [QTY_W-1:0]  m_qty, m_nqty;
    logic              m_side;
    order_t            o;          // entry captured by lookup
    logic              pend2;      // replace: add-side command still owed

    logic [IDX_W-1:0]  slot_cur, slot_new;
    logic              live_a, live_b, hit, new_taken;
    order_t            rd_data, wr_data;
    logic              wr_en, set_en, clr_en, up_en, dn_en;
    logic [IDX_W-1:0]  wr_idx, set_idx;
    logic              nx_add, nx_side;
    logic [PX_W-1:0]   nx_px;
    logic [QTY_W-1:0]  nx_qty, take, rest;

    assign slot_cur  = (state == S_IDLE) ? msg_ref[IDX_W-1:0] : m_ref[IDX_W-1:0];
    assign slot_new  = m_nref[IDX_W-1:0];
    assign hit       = live_a && (rd_data.oref == m_ref);
    assign new_taken = (m_kind == K_REPLACE) && live_b && (slot_new != m_ref[IDX_W-1:0]);

    oms_order_store #(.DEPTH(DEPTH)) store_i (
        .clk(clk), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .rd_en(state == S_LOOKUP), .rd_idx(m_ref[IDX_W-1:0]), .rd_data(rd_data)
    );

    oms_live_bits #(.DEPTH(DEPTH)) live_i (
        .clk(clk), .rst(rst),
        .set_en(set_en), .set_idx(set_idx),
        .clr_en(clr_en), .clr_idx(m_ref[IDX_W-1:0]),
        .rd_a_idx(slot_cur), .rd_a(live_a),
        .rd_b_idx(slot_new), .rd_b(live_b)
    );

    oms_side_counts #(.DEPTH(DEPTH)) cnt_i (
        .clk(clk), .rst(rst),
        .up_en(up_en), .up_side(m_side),
        .dn_en(dn_en), .dn_side(o.side),
        .buy_cnt(buy_orders), .sell_cnt(sell_orders)
    );

    // order update and the level action it implies
    always_comb begin
        take    = take_qty(m_qty, o.qty);
        rest    = o.qty - take;
        wr_en   = 1'b0;
        wr_idx  = m_ref[IDX_W-1:0];
        wr_data = o;
        set_en  = 1'b0;
        set_idx = m_ref[IDX_W-1:0];
        clr_en  = 1'b0;
        up_en   = 1'b0;
        dn_en   = 1'b0;
        nx_add  = 1'b0;
        nx_px   = o.price;
        nx_qty  = o.qty;
        nx_side = o.side;
        if (state == S_ORD_WR) begin
            case (m_kind)
                K_ADD: begin
                    wr_en         = 1'b1;
                    wr_data.oref  = m_ref;
                    wr_data.price = m_price;
                    wr_data.qty   = m_qty;
                    wr_data.side  = m_side;
                    wr_data.live  = 1'b1;
                    set_en        = 1'b1;
                    up_en         = 1'b1;
                    nx_add        = 1'b1;
                    nx_px         = m_price;
                    nx_qty        = m_qty;
                    nx_side       = m_side;
                end
                K_EXEC, K_CANCEL: begin
                    wr_en        = 1'b1;
                    wr_data.qty  = rest;
                    wr_data.live = (rest != '0);
                    clr_en       = (rest == '0);
                    dn_en        = (rest == '0);
                    nx_qty       = take;
                end
                K_DELETE: begin
                    wr_en        = 1'b1;
                    wr_data.live = 1'b0;
                    clr_en       = 1'b1;
                    dn_en        = 1'b1;
                end
                K_REPLACE: begin
                    wr_en         = 1'b1;
                    wr_idx        = slot_new;
                    wr_data.oref  = m_nref;
                    wr_data.price = m_nprice;
                    wr_data.qty   = m_nqty;
                    wr_data.live  = 1'b1;
                    clr_en        = 1'b1;
                    set_en        = 1'b1;
                    set_idx       = slot_new;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state         <= S_IDLE;
            msg_count     <= '0;
            pend2         <= 1'b0;
            m_kind        <= K_NONE;
            m_ref         <= '0;
            m_nref        <= '0;
            m_price       <= '0;
            m_nprice      <= '0;
            m_qty         <= '0;
            m_nqty        <= '0;
            m_side        <= 1'b0;
            o             <= '0;
            lvl_cmd_add   <= 1'b0;
            lvl_cmd_price <= '0;
            lvl_cmd_qty   <= '0;
            lvl_cmd_side  <= 1'b0;
        end else begin
            case (state)
                S_IDLE: if (msg_valid && kind_known(msg_kind)) begin
                    m_kind   <= msg_kind_e'(msg_kind);
                    m_ref    <= msg_ref;
                    m_price  <= msg_price;
                    m_qty    <= msg_shares;
                    m_side   <= msg_side;
                    m_nref   <= msg_new_ref;
                    m_nprice <= msg_new_price;
                    m_nqty   <= msg_new_shares;
                    if (msg_kind == K_ADD)
                        state <= live_a ? S_DONE : S_ORD_WR;
                    else
                        state <= S_LOOKUP;
                end
                S_LOOKUP:  state <= S_LK_WAIT;
                S_LK_WAIT: state <= S_CHECK;
                S_CHECK: begin
                    o     <= rd_data;
                    state <= (hit && !new_taken) ? S_ORD_WR : S_DONE;
                end
                S_ORD_WR: begin
                    lvl_cmd_add   <= nx_add;
                    lvl_cmd_price <= nx_px;
                    lvl_cmd_qty   <= nx_qty;
                    lvl_cmd_side  <= nx_side;
                    pend2         <= (m_kind == K_REPLACE);
                    state         <= S_ORD_W1;
                end
                S_ORD_W1: state <= S_ORD_W2;
                S_ORD_W2: state <= S_LVL;
                S_LVL:    state <= S_LVL_W1;
                S_LVL_W1: state <= S_LVL_W2;
                S_LVL_W2: begin
                    if (pend2) begin
                        pend2         <= 1'b0;
                        lvl_cmd_add   <= 1'b1;
                        lvl_cmd_price <= m_nprice;
                        lvl_cmd_qty   <= m_nqty;
                        state         <= S_LVL;
                    end else begin
                        state <= S_SCAN;
                    end
                end
                S_SCAN:      state <= S_SCAN_WAIT;
                S_SCAN_WAIT: if (scan_done) state <= S_DONE;
                S_DONE: begin
                    msg_count <= msg_count + 1'b1;
                    state     <= S_IDLE;
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    assign lvl_cmd_valid = (state == S_LVL);
    assign scan_start    = (state == S_SCAN);
    assign busy          = (state != S_IDLE);
endmodule

// File: rtl/oms_seq_chk.sv
`timescale 1ns/1ps
module oms_seq_chk #(
    parameter int DEPTH = 1024,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input logic           clk,
    input logic           rst,
    input logic           msg_valid,
    input logic [2:0]     msg_kind,
    input logic           lvl_cmd_valid,
    input logic           scan_start,
    input logic           busy,
    input logic [IDX_W:0] buy_orders,
    input logic [IDX_W:0] sell_orders,
    input logic [31:0]    msg_count
);
    // R1
    accept_rise_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy && msg_valid && msg_kind >= 3'd1 && msg_kind <= 3'd5) |=> busy);

    // R1
    stray_kind_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy && !(msg_valid && msg_kind >= 3'd1 && msg_kind <= 3'd5)) |=> !busy);

    // R12
    cmd_scan_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(lvl_cmd_valid && scan_start));

    // R12
    cmd_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        lvl_cmd_valid |=> !lvl_cmd_valid);

    // R12
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !(lvl_cmd_valid || scan_start));

    // R9
    scan_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        scan_start |=> !scan_start);

    // R10
    done_count_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> (msg_count == $past(msg_count) + 32'd1));

    // R10
    count_hold_chk: assert property (@(posedge clk) disable iff (rst)
        busy |=> (msg_count == $past(msg_count)) || !busy);

    // R6
    live_bound_chk: assert property (@(posedge clk) disable iff (rst)
        (32'(buy_orders) + 32'(sell_orders)) <= 32'(DEPTH));
endmodule

bind order_msg_sequencer oms_seq_chk #(.DEPTH(DEPTH)) chk_i (
    .clk(clk), .rst(rst), .msg_valid(msg_valid), .msg_kind(msg_kind),
    .lvl_cmd_valid(lvl_cmd_valid), .scan_start(scan_start), .busy(busy),
    .buy_orders(buy_orders), .sell_orders(sell_orders), .msg_count(msg_count)
);

// File: tb/order_msg_sequencer_tb.sv
`timescale 1ns/1ps
module order_msg_sequencer_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        msg_valid = 1'b0;
    logic [2:0]  msg_kind = 3'd0;
    logic [63:0] msg_ref = '0, msg_new_ref = '0;
    logic [31:0] msg_price = '0, msg_shares = '0, msg_new_price = '0, msg_new_shares = '0;
    logic        msg_side = 1'b0;
    logic        scan_done = 1'b0;
    logic        lvl_cmd_valid, lvl_cmd_add, lvl_cmd_side, scan_start, busy;
    logic [31:0] lvl_cmd_price, lvl_cmd_qty, msg_count;
    logic [10:0] buy_orders, sell_orders;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;   // 125 MHz

    order_msg_sequencer dut_i (
        .clk(clk), .rst(rst), .msg_valid(msg_valid), .msg_kind(msg_kind),
        .msg_ref(msg_ref), .msg_price(msg_price), .msg_shares(msg_shares),
        .msg_side(msg_side), .msg_new_ref(msg_new_ref), .msg_new_price(msg_new_price),
        .msg_new_shares(msg_new_shares), .lvl_cmd_valid(lvl_cmd_valid),
        .lvl_cmd_add(lvl_cmd_add), .lvl_cmd_price(lvl_cmd_price),
        .lvl_cmd_qty(lvl_cmd_qty), .lvl_cmd_side(lvl_cmd_side),
        .scan_start(scan_start), .scan_done(scan_done), .busy(busy),
        .buy_orders(buy_orders), .sell_orders(sell_orders), .msg_count(msg_count)
    );

    typedef struct packed {
        logic [2:0]  kind;
        logic [63:0] oref;
        logic [31:0] px;
        logic [31:0] qty;
        logic        side;
        logic [63:0] nref;
        logic [31:0] npx;
        logic [31:0] nqty;
        logic [1:0]  nlvl;
        logic        add1;
        logic [31:0] px1;
        logic [31:0] q1;
        logic        side1;
        logic [31:0] px2;
        logic [31:0] q2;
        logic [10:0] ebuy;
        logic [10:0] esell;
    } vec_t;

    localparam int NV = 15;
    localparam vec_t VECS [NV] = '{
        '{3'd1, 64'h100, 32'd1000, 32'd50, 1'b0, 64'h0, 32'd0, 32'd0, 2'd1, 1'b1, 32'd1000, 32'd50, 1'b0, 32'd0, 32'd0, 11'd1, 11'd0},
        '{3'd1, 64'h201, 32'd1100, 32'd30, 1'b1, 64'h0, 32'd0, 32'd0, 2'd1, 1'b1, 32'd1100, 32'd30, 1'b1, 32'd0, 32'd0, 11'd1, 11'd1},
        '{3'd2, 64'h100, 32'd0, 32'd20, 1'b0, 64'h0, 32'd0, 32'd0, 2'd1, 1'b0, 32'd1000, 32'd20, 1'b0, 32'd0, 32'd0, 11'd1, 11'd1},
        '{3'd3, 64'h100, 32'd0, 32'd100, 1'b0, 64'h0, 32'd0, 32'd0, 2'd1, 1'b0, 32'd1000, 32'd30, 1'b0, 32'd0, 32'd0, 11'd0, 11'd1},
        '{3'd2, 64'h100, 32'd0, 32'd5, 1'b0, 64'h0, 32'd0, 32'd0, 2'd0, 1'b0, 32'd0, 32'd0, 1'b0, 32'd0, 32'd0, 11'd0, 11'd1},
        '{3'd1, 64'h1_0000_0201, 32'd777, 32'd9, 1'b0, 64'h0, 32'd0, 32'd0, 2'd0, 1'b0, 32'd0, 32'd0, 1'b0, 32'd0, 32'd0, 11'd0, 11'd1},
        '{3'd4, 64'h1_0000_0201, 32'd0, 32'd0, 1'b0, 64'h0, 32'd0, 32'd0, 2'd0, 1'b0, 32'd0, 32'd0, 1'b0, 32'd0, 32'd0, 11'd0, 11'd1},
        '{3'd5, 64'h201, 32'd0, 32'd0, 1'b0, 64'h0AB, 32'd1090, 32'd40, 2'd2, 1'b0, 32'd1100, 32'd30, 1'b1, 32'd1090, 32'd40, 11'd0, 11'd1},
        '{3'd4, 64'h201, 32'd0, 32'd0, 1'b0, 64'h0, 32'd0, 32'd0, 2'd0, 1'b0, 32'd0, 32'd0, 1'b0, 32'd0, 32'd0, 11'd0, 11'd1},
        '{3'd4, 64'h0AB, 32'd0, 32'd0, 1'b0, 64'h0, 32'd0, 32'd0, 2'd1, 1'b0, 32'd1090, 32'd40, 1'b1, 32'd0, 32'd0, 11'd0, 11'd0},
        '{3'd1, 64'h3FF, 32'd900, 32'd10, 1'b0, 64'h0, 32'd0, 32'd0, 2'd1, 1'b1, 32'd900, 32'd10, 1'b0, 32'd0, 32'd0, 11'd1, 11'd0},
        '{3'd1, 64'h010, 32'd2000, 32'd7, 1'b1, 64'h0, 32'd0, 32'd0, 2'd1, 1'b1, 32'd2000, 32'd7, 1'b1, 32'd0, 32'd0, 11'd1, 11'd1},
        '{3'd5, 64'h3FF, 32'd0, 32'd0, 1'b0, 64'h010, 32'd5, 32'd5, 2'd0, 1'b0, 32'd0, 32'd0, 1'b0, 32'd0, 32'd0, 11'd1, 11'd1},
        '{3'd5, 64'h3FF, 32'd0, 32'd0, 1'b0, 64'h3FF, 32'd950, 32'd12, 2'd2, 1'b0, 32'd900, 32'd10, 1'b0, 32'd950, 32'd12, 11'd1, 11'd1},
        '{3'd2, 64'h3FF, 32'd0, 32'd12, 1'b0, 64'h0, 32'd0, 32'd0, 2'd1, 1'b0, 32'd950, 32'd12, 1'b0, 32'd0, 32'd0, 11'd0, 11'd1}
    };

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    // Sends one message and watches it to completion, cycle numbers counted from acceptance.
    task automatic run_vec(input vec_t v, input int idx);
        int    lc, so, first_off, last_off;
        int    lo [2];
        logic  la [2], ls [2];
        logic [31:0] lp [2], lq [2];
        string tag;
        lc = 0; so = -1;
        for (int k = 0; k < 2; k++) begin lo[k] = -1; la[k] = 0; ls[k] = 0; lp[k] = 0; lq[k] = 0; end
        @(negedge clk);
        msg_valid = 1'b1; msg_kind = v.kind; msg_ref = v.oref; msg_price = v.px;
        msg_shares = v.qty; msg_side = v.side; msg_new_ref = v.nref;
        msg_new_price = v.npx; msg_new_shares = v.nqty;
        @(negedge clk);
        msg_valid = 1'b0;
        for (int c = 1; c < 200; c++) begin
            if (c == 1) chk(busy == 1'b1, "R1", "busy after accept", busy, 1);
            if (lvl_cmd_valid) begin
                if (lc < 2) begin
                    lo[lc] = c; la[lc] = lvl_cmd_add; lp[lc] = lvl_cmd_price;
                    lq[lc] = lvl_cmd_qty; ls[lc] = lvl_cmd_side;
                end
                lc++;
            end
            if (scan_start) so = c;
            scan_done = (so >= 0) && (c == so + 2);
            if (!busy) break;
            if (c == 199) chk(1'b0, "R9", "message never completed", c, 0);
            @(negedge clk);
        end
        scan_done = 1'b0;

        if (v.nlvl == 0)            tag = (v.kind == 3'd1) ? "R11" : "R4";
        else if (v.kind == 3'd1)    tag = "R2";
        else if (v.kind == 3'd4)    tag = "R7";
        else if (v.kind == 3'd5)    tag = "R8";
        else                        tag = "R5";

        chk(lc == int'(v.nlvl), tag, $sformatf("vec %0d level command count", idx), lc, v.nlvl);
        first_off = (v.kind == 3'd1) ? 4 : 7;
        if (v.nlvl >= 1) begin
            chk(lo[0] == first_off, (v.kind == 3'd1) ? "R2" : "R3",
                $sformatf("vec %0d first command cycle", idx), lo[0], first_off);
            chk(la[0] == v.add1, tag, $sformatf("vec %0d cmd1 add", idx), la[0], v.add1);
            chk(lp[0] == v.px1, tag, $sformatf("vec %0d cmd1 price", idx), lp[0], v.px1);
            chk(lq[0] == v.q1, tag, $sformatf("vec %0d cmd1 qty", idx), lq[0], v.q1);
            chk(ls[0] == v.side1, tag, $sformatf("vec %0d cmd1 side", idx), ls[0], v.side1);
        end
        if (v.nlvl == 2) begin
            chk(lo[1] == first_off + 3, "R8", $sformatf("vec %0d cmd2 cycle", idx), lo[1], first_off + 3);
            chk(la[1] == 1'b1, "R8", $sformatf("vec %0d cmd2 add", idx), la[1], 1);
            chk(lp[1] == v.px2, "R8", $sformatf("vec %0d cmd2 price", idx), lp[1], v.px2);
            chk(lq[1] == v.q2, "R8", $sformatf("vec %0d cmd2 qty", idx), lq[1], v.q2);
            chk(ls[1] == v.side1, "R8", $sformatf("vec %0d cmd2 side", idx), ls[1], v.side1);
        end
        last_off = (v.nlvl == 0) ? -1 : ((v.nlvl == 2) ? lo[1] : lo[0]);
        chk(so == ((v.nlvl == 0) ? -1 : last_off + 3), "R9",
            $sformatf("vec %0d scan pulse cycle", idx), so, (v.nlvl == 0) ? -1 : last_off + 3);
        chk(buy_orders == v.ebuy, "R6", $sformatf("vec %0d buy count", idx), buy_orders, v.ebuy);
        chk(sell_orders == v.esell, "R6", $sformatf("vec %0d sell count", idx), sell_orders, v.esell);
        chk(msg_count == 32'(idx + 1), "R10", $sformatf("vec %0d msg count", idx), msg_count, idx + 1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        chk(1'b0, "watchdog", "run did not end", 0, 1);
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R13 reset state
        chk(busy == 0 && msg_count == 0, "R13", "busy/msg_count after reset", msg_count, 0);
        chk(buy_orders == 0 && sell_orders == 0, "R13", "live counts after reset", buy_orders, 0);
        chk(!lvl_cmd_valid && !scan_start, "R13", "outputs quiet after reset", lvl_cmd_valid, 0);

        for (int i = 0; i < NV; i++) run_vec(VECS[i], i);

        // R1: unknown kind codes ignored
        foreach (VECS[i]) ;
        for (int kc = 0; kc < 3; kc++) begin
            @(negedge clk);
            msg_valid = 1'b1;
            msg_kind = (kc == 0) ? 3'd0 : ((kc == 1) ? 3'd6 : 3'd7);
            msg_ref = 64'h3FF;
            for (int c = 0; c < 3; c++) begin
                @(negedge clk);
                chk(busy == 0 && !lvl_cmd_valid, "R1", "unknown kind ignored", busy, 0);
            end
            msg_valid = 1'b0;
        end
        chk(msg_count == 32'd15, "R1", "msg count after unknown kinds", msg_count, 15);

        // R13: reset in the middle of a message
        @(negedge clk);
        msg_valid = 1'b1; msg_kind = 3'd1; msg_ref = 64'h055; msg_price = 32'd300;
        msg_shares = 32'd4; msg_side = 1'b0;
        @(negedge clk);
        msg_valid = 1'b0;
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk(busy == 0 && msg_count == 0, "R13", "reset mid-message", msg_count, 0);
        chk(buy_orders == 0 && sell_orders == 0, "R13", "counts after mid reset", sell_orders, 0);

        // R13: order 0x010 was live before reset; a delete must now miss
        run_vec('{3'd4, 64'h010, 32'd0, 32'd0, 1'b0, 64'h0, 32'd0, 32'd0, 2'd0, 1'b0,
                  32'd0, 32'd0, 1'b0, 32'd0, 32'd0, 11'd0, 11'd0}, 0);

        summary();
        $finish;
    end
endmodule